// File: doc/BRIEF.md
# Vectored Interrupt Controller with Global Enable

The block collects interrupt events from three sources: a selectable edge on an external pin, a change on a four-bit group of port inputs, and a timer wrap strobe. Each source has a sticky flag, an individual mask and a shared global enable, all held in one 8-bit control register. Software can read and write this register. An event sets its flag whether or not the source is masked. The flag then stays set until software writes it to zero.

When the global enable is set, some flag is set together with its mask, and the processor signals an instruction boundary, the block raises `take_o` for that cycle. In the same cycle it presents the interrupt vector address. The processor uses `take_o` to push its return address and load the vector. On the next clock the block clears the global enable itself, and a return-from-interrupt strobe sets it again.

Asynchronous pin inputs pass through a two-stage synchroniser before edge or change detection. The port-change source compares the synchronised inputs against a snapshot taken each time the processor reads the port.

Top module: `irq_ctrl`

## Requirements
- R1: After reset the control register reads 0x00, `take_o` is 0 and `vec_o` is 0x000.
- R2: Control bit 7 selects the external edge: 1 means rising, 0 means falling. The matching edge sets the flag at bit 4, which is readable three rising clock edges after the pin changes. The opposite edge sets nothing.
- R3: While the synchronised port inputs differ from the snapshot latched on `port_rd_i`, the flag at bit 5 is set. It is readable three edges after the inputs change. Inputs equal to the snapshot set nothing.
- R4: A one-cycle `tmr_wrap_i` pulse sets the flag at bit 6 on the next clock edge.
- R5: Flags are set regardless of the masks (bits 1, 2 and 3) and of the global enable (bit 0). A flag stays set until software writes 0 to it.
- R6: `take_o` equals `boundary_i` AND global enable AND (OR over the flags ANDed with their masks), with no cycle of delay. `vec_o` is 0x004 while `take_o` is 1 and 0x000 otherwise.
- R7: A take clears the global enable on the next edge, even if a write of 1 to bit 0 happens in the same cycle.
- R8: A `reti_i` pulse with no take sets the global enable on the next edge.
- R9: A flag left set while masked causes a take as soon as its mask is set.
- R10: An event in the same cycle as a software write that clears its flag leaves the flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ext_pin_i | input | 1 | External interrupt pin, asynchronous |
| port_hi_i | input | 4 | Watched port inputs, asynchronous |
| port_rd_i | input | 1 | Port read strobe; latches the change snapshot |
| tmr_wrap_i | input | 1 | Timer wrap strobe, one cycle |
| ctl_we_i | input | 1 | Control register write enable |
| ctl_wdata_i | input | 8 | Control register write data |
| ctl_rdata_o | output | 8 | Control register contents |
| boundary_i | input | 1 | Instruction boundary strobe |
| reti_i | input | 1 | Return-from-interrupt strobe |
| take_o | output | 1 | Take interrupt (push return address, load vector) |
| vec_o | output | 13 | Vector address |

## Verification
The external pin is driven with both edge directions under both edge selections. This separates a correct edge detector from one that reacts to any transition or to the wrong polarity. The port group is driven with a value that differs from its snapshot, then read, then held, then changed again. This shows that the comparison is made against the snapshot and not against the previous sample. Take decisions are tried with the boundary low, with the source masked and with the global enable set. They are also tried with a same-cycle write and with a same-cycle event against a clearing write, which exposes priority mistakes between hardware and software updates.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int unsigned CTL_W     = 8;
  localparam int unsigned B_GIE     = 0;
  localparam int unsigned B_EXT_EN  = 1;
  localparam int unsigned B_PORT_EN = 2;
  localparam int unsigned B_TMR_EN  = 3;
  localparam int unsigned B_EXT_FL  = 4;
  localparam int unsigned B_PORT_FL = 5;
  localparam int unsigned B_TMR_FL  = 6;
  localparam int unsigned B_RISE    = 7;
  localparam int unsigned N_SRC     = 3;
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= '0;
    end else begin
      stg_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/irq_event_det.sv
module irq_event_det #(
  parameter int unsigned PORT_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ext_s_i,
  input  logic [PORT_W-1:0] port_s_i,
  input  logic              rise_sel_i,
  input  logic              port_rd_i,
  output logic              ext_evt_o,
  output logic              port_evt_o
);
  logic              ext_prev_q;
  logic [PORT_W-1:0] snap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ext_prev_q <= 1'b0;
      snap_q     <= '0;
    end else begin
      ext_prev_q <= ext_s_i;
      if (port_rd_i) snap_q <= port_s_i;
    end
  end

  assign ext_evt_o  = rise_sel_i ? (ext_s_i & ~ext_prev_q) : (~ext_s_i & ext_prev_q);
  assign port_evt_o = |(port_s_i ^ snap_q);

  // R3: a port read refreshes the comparison snapshot
  assert_snap_load_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    port_rd_i |=> (snap_q == $past(port_s_i)));
endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl
  import irq_pkg::*;
#(
  parameter int unsigned PORT_W  = 4,
  parameter int unsigned SYNC_N  = 2,
  parameter int unsigned VEC_W   = 13,
  parameter int unsigned IRQ_VEC = 4,
  parameter int unsigned RST_VEC = 0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ext_pin_i,
  input  logic [PORT_W-1:0] port_hi_i,
  input  logic              port_rd_i,
  input  logic              tmr_wrap_i,
  input  logic              ctl_we_i,
  input  logic [CTL_W-1:0]  ctl_wdata_i,
  output logic [CTL_W-1:0]  ctl_rdata_o,
  input  logic              boundary_i,
  input  logic              reti_i,
  output logic              take_o,
  output logic [VEC_W-1:0]  vec_o
);
  localparam int unsigned SW = PORT_W + 1;

  logic [CTL_W-1:0]  ctl_q, ctl_d;
  logic [SW-1:0]     raw_in, sync_out;
  logic              ext_evt, port_evt;
  logic [N_SRC-1:0]  flags, masks, events;

  assign raw_in = {port_hi_i, ext_pin_i};

  irq_sync #(.W(SW), .STAGES(SYNC_N)) i_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (raw_in),
    .q_o   (sync_out)
  );

  irq_event_det #(.PORT_W(PORT_W)) i_det (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ext_s_i   (sync_out[0]),
    .port_s_i  (sync_out[SW-1:1]),
    .rise_sel_i(ctl_q[B_RISE]),
    .port_rd_i (port_rd_i),
    .ext_evt_o (ext_evt),
    .port_evt_o(port_evt)
  );

  assign flags  = {ctl_q[B_TMR_FL], ctl_q[B_PORT_FL], ctl_q[B_EXT_FL]};
  assign masks  = {ctl_q[B_TMR_EN], ctl_q[B_PORT_EN], ctl_q[B_EXT_EN]};
  assign events = {tmr_wrap_i, port_evt, ext_evt};

  assign take_o = boundary_i & ctl_q[B_GIE] & |(flags & masks);
  assign vec_o  = take_o ? VEC_W'(IRQ_VEC) : VEC_W'(RST_VEC);

  // hardware events win over software clears; take wins over reti and writes
  always_comb begin
    ctl_d = ctl_we_i ? ctl_wdata_i : ctl_q;
    if (events[0]) ctl_d[B_EXT_FL]  = 1'b1;
    if (events[1]) ctl_d[B_PORT_FL] = 1'b1;
    if (events[2]) ctl_d[B_TMR_FL]  = 1'b1;
    if (reti_i)    ctl_d[B_GIE]     = 1'b1;
    if (take_o)    ctl_d[B_GIE]     = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ctl_q <= '0;
    else         ctl_q <= ctl_d;
  end

  assign ctl_rdata_o = ctl_q;

  // R7: taking an interrupt drops the global enable
  assert_take_clears_gie_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o |=> !ctl_rdata_o[B_GIE]);
  // R8: return re-enables
  assert_reti_sets_gie_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reti_i && !take_o) |=> ctl_rdata_o[B_GIE]);
  // R4: timer wrap latches its flag
  assert_tmr_flag_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tmr_wrap_i |=> ctl_rdata_o[B_TMR_FL]);
  // R5: without a write no flag ever falls
  assert_flags_sticky_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctl_we_i |=> ((flags & $past(flags)) == $past(flags)));
  // R6: vector only while taking
  assert_vec_sel_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !take_o |-> (vec_o == VEC_W'(RST_VEC)));
endmodule

// File: tb/test_irq_ctrl.sv
module test_irq_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ext_pin = 1'b0;
  logic [3:0]  port_hi = '0;
  logic        port_rd = 1'b0;
  logic        tmr_wrap = 1'b0;
  logic        ctl_we = 1'b0;
  logic [7:0]  ctl_wdata = '0;
  logic [7:0]  ctl_rdata;
  logic        boundary = 1'b0;
  logic        reti = 1'b0;
  logic        take;
  logic [12:0] vec;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  irq_ctrl i_irq_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .ext_pin_i(ext_pin), .port_hi_i(port_hi),
    .port_rd_i(port_rd), .tmr_wrap_i(tmr_wrap), .ctl_we_i(ctl_we),
    .ctl_wdata_i(ctl_wdata), .ctl_rdata_o(ctl_rdata), .boundary_i(boundary),
    .reti_i(reti), .take_o(take), .vec_o(vec)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] d);
    @(negedge clk); ctl_we = 1'b1; ctl_wdata = d;
    @(negedge clk); ctl_we = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset_R1;
    chk(ctl_rdata == 8'h00, "R1 ctl", ctl_rdata, 8'h00);
    chk(take == 1'b0, "R1 take", take, 0);
    chk(vec == 13'h000, "R1 vec", vec, 0);
  endtask

  task automatic t_ext_R2;
    wr(8'h80);
    ext_pin = 1'b1;
    idle(2);
    chk(ctl_rdata[4] == 1'b0, "R2 rise not yet", ctl_rdata[4], 0);
    idle(1);
    chk(ctl_rdata == 8'h90, "R2 rise flag", ctl_rdata, 8'h90);
    wr(8'h80);
    ext_pin = 1'b0;
    idle(4);
    chk(ctl_rdata == 8'h80, "R2 fall ignored when rising", ctl_rdata, 8'h80);
    wr(8'h00);
    ext_pin = 1'b1;
    idle(4);
    chk(ctl_rdata == 8'h00, "R2 rise ignored when falling", ctl_rdata, 8'h00);
    ext_pin = 1'b0;
    idle(3);
    chk(ctl_rdata == 8'h10, "R2 fall flag", ctl_rdata, 8'h10);
    wr(8'h00);
  endtask

  task automatic t_port_R3;
    port_hi = 4'h5;
    idle(3);
    chk(ctl_rdata == 8'h20, "R3 change flag", ctl_rdata, 8'h20);
    port_rd = 1'b1; idle(1); port_rd = 1'b0;
    wr(8'h00);
    idle(3);
    chk(ctl_rdata == 8'h00, "R3 equal to snapshot", ctl_rdata, 8'h00);
    port_hi = 4'h4;
    idle(3);
    chk(ctl_rdata == 8'h20, "R3 second change", ctl_rdata, 8'h20);
    port_rd = 1'b1; idle(1); port_rd = 1'b0;
    wr(8'h00);
  endtask

  task automatic t_tmr_R4_R5;
    tmr_wrap = 1'b1; idle(1); tmr_wrap = 1'b0;
    chk(ctl_rdata == 8'h40, "R4 timer flag", ctl_rdata, 8'h40);
    boundary = 1'b1; #1;
    chk(take == 1'b0, "R5 masked no take", take, 0);
    idle(3);
    boundary = 1'b0;
    chk(ctl_rdata == 8'h40, "R5 flag held", ctl_rdata, 8'h40);
    wr(8'h00);
    chk(ctl_rdata == 8'h00, "R5 software clear", ctl_rdata, 8'h00);
  endtask

  task automatic t_take_R6_R7_R8;
    wr(8'h09);
    tmr_wrap = 1'b1; idle(1); tmr_wrap = 1'b0;
    #1;
    chk(take == 1'b0, "R6 no boundary", take, 0);
    chk(vec == 13'h000, "R6 vec idle", vec, 0);
    boundary = 1'b1; ctl_we = 1'b1; ctl_wdata = 8'h49; #1;
    chk(take == 1'b1, "R6 take", take, 1);
    chk(vec == 13'h004, "R6 vec", vec, 4);
    @(negedge clk); boundary = 1'b0; ctl_we = 1'b0; #1;
    chk(ctl_rdata == 8'h48, "R7 gie cleared over write", ctl_rdata, 8'h48);
    chk(take == 1'b0, "R7 take drops", take, 0);
    reti = 1'b1; idle(1); reti = 1'b0;
    chk(ctl_rdata == 8'h49, "R8 reti sets gie", ctl_rdata, 8'h49);
    wr(8'h00);
  endtask

  task automatic t_pending_R9;
    tmr_wrap = 1'b1; idle(1); tmr_wrap = 1'b0;
    wr(8'h41);
    boundary = 1'b1; #1;
    chk(take == 1'b0, "R9 masked pending", take, 0);
    wr(8'h49); #1;
    chk(take == 1'b1, "R9 fires on enable", take, 1);
    boundary = 1'b0;
    wr(8'h00);
  endtask

  task automatic t_race_R10;
    tmr_wrap = 1'b1; idle(1); tmr_wrap = 1'b0;
    ctl_we = 1'b1; ctl_wdata = 8'h00; tmr_wrap = 1'b1;
    @(negedge clk); ctl_we = 1'b0; tmr_wrap = 1'b0;
    chk(ctl_rdata == 8'h40, "R10 event beats clear", ctl_rdata, 8'h40);
    wr(8'h00);
  endtask

  initial begin
    idle(2);
    t_reset_R1;
    rst_n = 1'b1;
    idle(1);
    t_ext_R2;
    t_port_R3;
    t_tmr_R4_R5;
    t_take_R6_R7_R8;
    t_pending_R9;
    t_race_R10;
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule